// File: doc/BRIEF.md
# UART Modem Status Tracker

This block keeps the modem-line side of a classic serial port. It watches four incoming handshake lines: clear-to-send, data-set-ready, ring and carrier detect. Each line passes through a synchroniser. The block stores the current level of each line and records every change in a sticky change flag. It also holds the five-bit modem control word, which drives the outgoing handshake pins and selects a loopback test mode.

Software reads the status byte through a read strobe. The returned byte holds the line levels in the high nibble and the change flags in the low nibble. The read clears the change flags. A single change indication output is high while any change flag is set.

In loopback the status read shows the control outputs instead of the external lines. The external terminal-ready and request-to-send pins are held inactive in this mode. Changes on the external lines raise no flag while loopback is on.

Top module: `modem_status_tracker`

## Requirements
- R1: After reset the status read returns 0xB0 (carrier, data-set-ready and clear-to-send high, no change flags), the control readback is 0x08, out2_o is 1, dtr_o, rts_o, out1_o and loop_o are 0, and modem_irq_o is 0.
- R2: A change in either direction on clear-to-send, data-set-ready or carrier sets its change flag: bit 0, bit 1 and bit 3 of the status byte.
- R3: The ring change flag (bit 2) is set only when the ring line falls from 1 to 0. A rising ring line sets no flag.
- R4: A status read returns the line levels in bits 7..4 (carrier bit 7, ring bit 6, data-set-ready bit 5, clear-to-send bit 4) and the change flags in bits 3..0. The byte appears on sts_rdata_o one cycle after the strobe. The read clears all four change flags.
- R5: If a line change would set its flag in the same cycle as a clearing read, the new flag survives the clear. The returned byte does not include that new flag.
- R6: modem_irq_o is high exactly when at least one of the four change flags is set.
- R7: A control write keeps only the low five bits: bit 0 terminal-ready, bit 1 request-to-send, bit 2 out1, bit 3 out2, bit 4 loopback. ctl_rdata_o returns them with bits 7..5 at zero, one cycle after the write.
- R8: dtr_o, rts_o, out1_o, out2_o and loop_o follow their control bits. In loopback, dtr_o and rts_o are forced to 0.
- R9: In loopback a status read returns out2 in bit 7, out1 in bit 6, terminal-ready in bit 5, request-to-send in bit 4 and zero in bits 3..0. External line changes set no flag in loopback. Flags already pending are neither changed nor cleared until loopback ends.
- R10: An external line change shows in modem_irq_o exactly SYNC_STAGES+1 clock edges after it is applied (3 edges by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_cts_i | input | 1 | Clear-to-send line, active high |
| line_dsr_i | input | 1 | Data-set-ready line, active high |
| line_ri_i | input | 1 | Ring line, active high |
| line_dcd_i | input | 1 | Carrier detect line, active high |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 8 | Control write data |
| ctl_rdata_o | output | 8 | Control word readback |
| sts_rd_i | input | 1 | Status read strobe (clears change flags) |
| sts_rdata_o | output | 8 | Status byte captured by the last read |
| dtr_o | output | 1 | Terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| loop_o | output | 1 | Loopback mode active |
| modem_irq_o | output | 1 | Any change flag set |

## Verification
Two events can fall in the same clock edge: a clearing status read, and a synchronised line change that sets a change flag.

The bench sets up this collision on purpose. It first leaves a data-set-ready flag pending. It then changes clear-to-send and raises the read strobe exactly SYNC_STAGES edges later, so the read lands on the edge where the new flag is set.

The check has three parts:
- The returned byte shows only the old flag and the pre-change levels.
- modem_irq_o stays high.
- A second read returns exactly the new clear-to-send flag.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int REG_W   = 8;
  localparam int LINES   = 4;
  localparam int CTL_W   = 5;

  // line vector index (also low-nibble flag position)
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;

  // control word bit positions
  localparam int C_DTR   = 0;
  localparam int C_RTS   = 1;
  localparam int C_OUT1  = 2;
  localparam int C_OUT2  = 3;
  localparam int C_LOOP  = 4;

  typedef logic [LINES-1:0] line_vec_t;
  typedef logic [CTL_W-1:0] ctl_vec_t;

  localparam line_vec_t LINE_RST = 4'b1011; // dcd, ri, dsr, cts
  localparam ctl_vec_t  CTL_RST  = 5'b01000;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg_q[s] <= RST_VAL;
          else     stg_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg_q[s] <= RST_VAL;
          else     stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/msr_ctl.sv
module msr_ctl
  import msr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             loop_o,
  output logic [REG_W-1:0] loop_view_o,
  output logic             dtr_o,
  output logic             rts_o,
  output logic             out1_o,
  output logic             out2_o
);
  ctl_vec_t ctl_q, ctl_d;
  logic     dtr_q, rts_q, out1_q, out2_q;
  logic     wdata_unused;

  assign wdata_unused = ^wdata_i[REG_W-1:CTL_W];

  always_comb begin
    ctl_d = ctl_q;
    if (wr_i) ctl_d = wdata_i[CTL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= CTL_RST;
      dtr_q  <= 1'b0;
      rts_q  <= 1'b0;
      out1_q <= CTL_RST[C_OUT1];
      out2_q <= CTL_RST[C_OUT2];
    end else begin
      ctl_q  <= ctl_d;
      dtr_q  <= ctl_d[C_DTR] & ~ctl_d[C_LOOP];
      rts_q  <= ctl_d[C_RTS] & ~ctl_d[C_LOOP];
      out1_q <= ctl_d[C_OUT1];
      out2_q <= ctl_d[C_OUT2];
    end
  end

  assign rdata_o = {{(REG_W-CTL_W){1'b0}}, ctl_q};
  assign loop_o  = ctl_q[C_LOOP];
  assign dtr_o   = dtr_q;
  assign rts_o   = rts_q;
  assign out1_o  = out1_q;
  assign out2_o  = out2_q;
  // control outputs folded onto the status level positions
  assign loop_view_o = {ctl_q[C_OUT2], ctl_q[C_OUT1], ctl_q[C_DTR], ctl_q[C_RTS], 4'b0000};

  // R8: loopback keeps terminal-ready and request-to-send low
  assert_loop_pins_low_R8: assert property (@(posedge clk) disable iff (rst)
    ctl_q[C_LOOP] |-> (!dtr_q && !rts_q));

  // R7: a write is reflected in the readback one cycle later
  assert_ctl_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (rdata_o == {{(REG_W-CTL_W){1'b0}}, $past(wdata_i[CTL_W-1:0])}));
endmodule

// File: rtl/msr_track.sv
module msr_track
  import msr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  line_vec_t        sync_i,
  input  logic             loop_i,
  input  logic [REG_W-1:0] loop_view_i,
  input  logic             rd_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  line_vec_t        lvl_q, dlt_q, dlt_d, chg, set_v, keep_v;
  logic [REG_W-1:0] rd_q;
  logic             irq_q;

  always_comb begin
    chg = sync_i ^ lvl_q;
    set_v = '0;
    if (!loop_i) begin
      set_v[IDX_CTS] = chg[IDX_CTS];
      set_v[IDX_DSR] = chg[IDX_DSR];
      set_v[IDX_DCD] = chg[IDX_DCD];
      set_v[IDX_RI]  = lvl_q[IDX_RI] & ~sync_i[IDX_RI];
    end
    keep_v = (rd_i && !loop_i) ? '0 : dlt_q;
    dlt_d  = keep_v | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= LINE_RST;
      dlt_q <= '0;
      irq_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      lvl_q <= sync_i;
      dlt_q <= dlt_d;
      irq_q <= |dlt_d;
      if (rd_i) rd_q <= loop_i ? loop_view_i : {lvl_q, dlt_q};
    end
  end

  assign rdata_o = rd_q;
  assign irq_o   = irq_q;

  // R2: a sampled change on a non-ring line raises its flag
  assert_cts_change_R2: assert property (@(posedge clk) disable iff (rst)
    (!loop_i && (sync_i[IDX_CTS] != lvl_q[IDX_CTS])) |=> dlt_q[IDX_CTS]);
  assert_dcd_change_R2: assert property (@(posedge clk) disable iff (rst)
    (!loop_i && (sync_i[IDX_DCD] != lvl_q[IDX_DCD])) |=> dlt_q[IDX_DCD]);

  // R3: a rising ring line does not raise a clear ring flag
  assert_ri_rise_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (!lvl_q[IDX_RI] && sync_i[IDX_RI] && !dlt_q[IDX_RI]) |=> !dlt_q[IDX_RI]);

  // R4: a read with no new change leaves every flag clear
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !loop_i && (sync_i == lvl_q)) |=> (dlt_q == '0));

  // R6: change indication tracks the flag set
  assert_irq_or_R6: assert property (@(posedge clk) disable iff (rst)
    irq_q == (dlt_q != '0));

  // R9: loopback freezes the flags
  assert_loop_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    loop_i |=> $stable(dlt_q));
endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_cts_i,
  input  logic       line_dsr_i,
  input  logic       line_ri_i,
  input  logic       line_dcd_i,
  input  logic       ctl_wr_i,
  input  logic [7:0] ctl_wdata_i,
  output logic [7:0] ctl_rdata_o,
  input  logic       sts_rd_i,
  output logic [7:0] sts_rdata_o,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       loop_o,
  output logic       modem_irq_o
);
  line_vec_t        raw_lines, sync_lines;
  logic             loop_w;
  logic [REG_W-1:0] loop_view;

  always_comb begin
    raw_lines          = '0;
    raw_lines[IDX_CTS] = line_cts_i;
    raw_lines[IDX_DSR] = line_dsr_i;
    raw_lines[IDX_RI]  = line_ri_i;
    raw_lines[IDX_DCD] = line_dcd_i;
  end

  msr_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_lines),
    .q_o (sync_lines)
  );

  msr_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (ctl_wr_i),
    .wdata_i     (ctl_wdata_i),
    .rdata_o     (ctl_rdata_o),
    .loop_o      (loop_w),
    .loop_view_o (loop_view),
    .dtr_o       (dtr_o),
    .rts_o       (rts_o),
    .out1_o      (out1_o),
    .out2_o      (out2_o)
  );

  msr_track u_track (
    .clk         (clk),
    .rst         (rst),
    .sync_i      (sync_lines),
    .loop_i      (loop_w),
    .loop_view_i (loop_view),
    .rd_i        (sts_rd_i),
    .rdata_o     (sts_rdata_o),
    .irq_o       (modem_irq_o)
  );

  assign loop_o = loop_w;
endmodule

// File: tb/modem_status_tracker_tb.sv
module modem_status_tracker_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cts = 1'b1, dsr = 1'b1, ri = 1'b0, dcd = 1'b1;
  logic ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic sts_rd = 1'b0;
  logic [7:0] sts_rdata;
  logic dtr, rts, out1, out2, loopm, irq;
  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  modem_status_tracker #(.SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst),
    .line_cts_i(cts), .line_dsr_i(dsr), .line_ri_i(ri), .line_dcd_i(dcd),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
    .sts_rd_i(sts_rd), .sts_rdata_o(sts_rdata),
    .dtr_o(dtr), .rts_o(rts), .out1_o(out1), .out2_o(out2),
    .loop_o(loopm), .modem_irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sts_read(output logic [7:0] v);
    sts_rd = 1'b1;
    tick(1);
    sts_rd = 1'b0;
    v = sts_rdata;
  endtask

  task automatic ctl_write(input logic [7:0] v);
    ctl_wdata = v;
    ctl_wr = 1'b1;
    tick(1);
    ctl_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 ctl", ctl_rdata, 8'h08);
    chk("R1 pins", {3'd0, loopm, out2, out1, rts, dtr}, 8'h08);
    sts_read(v);
    chk("R1 status", v, 8'hB0);
  endtask

  task automatic t_latency();
    logic [7:0] v;
    cts = 1'b0;
    tick(2);
    chk("R10 before", {7'd0, irq}, 8'h00);
    tick(1);
    chk("R10 at", {7'd0, irq}, 8'h01);
    sts_read(v);
    chk("R4 read", v, 8'hA1);
    chk("R6 cleared", {7'd0, irq}, 8'h00);
    sts_read(v);
    chk("R4 after clear", v, 8'hA0);
  endtask

  task automatic t_lines();
    logic [7:0] v;
    dsr = 1'b0; dcd = 1'b0;
    tick(4);
    sts_read(v);
    chk("R2 fall", v, 8'h0A);
    cts = 1'b1; dsr = 1'b1; dcd = 1'b1;
    tick(4);
    chk("R6 set", {7'd0, irq}, 8'h01);
    sts_read(v);
    chk("R2 rise", v, 8'hBB);
    sts_read(v);
    chk("R4 clean", v, 8'hB0);
  endtask

  task automatic t_ring();
    logic [7:0] v;
    ri = 1'b1;
    tick(4);
    chk("R3 rise irq", {7'd0, irq}, 8'h00);
    sts_read(v);
    chk("R3 rise", v, 8'hF0);
    ri = 1'b0;
    tick(4);
    chk("R3 fall irq", {7'd0, irq}, 8'h01);
    sts_read(v);
    chk("R3 fall", v, 8'hB4);
    sts_read(v);
    chk("R3 clean", v, 8'hB0);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    dsr = 1'b0;
    tick(4);
    cts = 1'b0;
    tick(2);
    sts_read(v);
    chk("R5 returned", v, 8'h92);
    chk("R5 irq kept", {7'd0, irq}, 8'h01);
    sts_read(v);
    chk("R5 survivor", v, 8'h81);
    cts = 1'b1; dsr = 1'b1;
    tick(4);
    sts_read(v);
    chk("R5 restore", v, 8'hB3);
    sts_read(v);
    chk("R5 clean", v, 8'hB0);
  endtask

  task automatic t_control();
    ctl_write(8'hFF);
    chk("R7 mask", ctl_rdata, 8'h1F);
    chk("R8 loop pins", {3'd0, loopm, out2, out1, rts, dtr}, 8'h1C);
    ctl_write(8'hE3);
    chk("R7 low", ctl_rdata, 8'h03);
    chk("R8 normal pins", {3'd0, loopm, out2, out1, rts, dtr}, 8'h03);
  endtask

  task automatic t_loop();
    logic [7:0] v;
    dsr = 1'b0;
    tick(4);
    ctl_write(8'h15);
    sts_read(v);
    chk("R9 view a", v, 8'h60);
    ctl_write(8'h1A);
    sts_read(v);
    chk("R9 view b", v, 8'h90);
    chk("R9 pending kept", {7'd0, irq}, 8'h01);
    cts = 1'b0;
    tick(4);
    ctl_write(8'h08);
    sts_read(v);
    chk("R9 exit", v, 8'h82);
    cts = 1'b1; dsr = 1'b1;
    tick(4);
    sts_read(v);
    chk("R9 restore", v, 8'hB3);
    sts_read(v);
    chk("R9 clean", v, 8'hB0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_latency();
    t_lines();
    t_ring();
    t_collide();
    t_control();
    t_loop();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule